// File: doc/BRIEF.md
# Column Burst Sequencer with Interrupt and Auto-Precharge

This block sits between a command decoder and a double-data-rate storage array. It receives decoded commands with a start column, a burst-length code and an order bit. For each read or write it emits the column addresses of the burst, two beats per clock, with a valid flag, a write flag and a per-beat byte-mask. It also tracks the minimum active time of each bank and issues one internal precharge strobe after a read or write that requested auto-precharge.

A new read or write drops whatever is left of the current burst and starts a full-length burst at the new column. A stop command cuts a read burst short. A stop command during a write burst is flagged as a protocol error and does not stop the write. Read data latency lies downstream and is fixed. The beats of an interrupted read therefore keep arriving at the pads until the new burst's latency has passed.

Burst state machine: `B_IDLE`, `B_READ`, `B_WRITE`. Its transitions are:
- start-read and start-write, taken from any state on a read or write command;
- advance, from one pair to the next;
- done, from the last pair to `B_IDLE`;
- stop, from `B_READ` to `B_IDLE` on a stop command.

Precharge scheduler: `AP_IDLE`, `AP_WAIT`, `AP_LOCK`. Its transitions are:
- arm, from any state on a read or write with the auto-precharge bit;
- fire, from `AP_WAIT` to `AP_LOCK` when the delay has run out and the bank's active time is met;
- release, from `AP_LOCK` to `AP_IDLE`.

Top module: `burst_seq`

## Requirements
- R1: Command codes on `cmd_i` are 0 no-op, 1 activate, 2 read, 3 write and 4 stop. A read or write sampled at a clock edge shows beats 0 and 1 on `col_even_o`/`col_odd_o` in the next cycle, with `beat_vld_o` high. The next pair follows in each later cycle. With `ilv_i`=0 the low bits count up modulo the burst length inside an aligned block, and the upper bits are kept.
- R2: With `ilv_i`=1 the low bits of beat i equal the start column's low bits XOR i.
- R3: `bl_code_i` 1, 2 and 3 select bursts of 2, 4 and 8 beats (code 0 acts as 2). A burst holds `beat_vld_o` for exactly length/2 cycles, and `beat_vld_o` then drops unless another command arrived. `beat_wr_o` is 1 for writes and 0 for reads.
- R4: A read or write arriving during a read burst, to any bank, discards the remaining beats. From the next cycle a full-length burst runs at the new column, and `beat_bank_o` shows the new bank.
- R5: A write issued in the cycle right after another write replaces it and runs for the full burst length.
- R6: A stop command during a read burst ends the burst: `beat_vld_o` is low from the next cycle. A stop command with no burst in progress changes no output.
- R7: A stop command during a write burst raises `bst_err_o` in that same cycle. The write continues unchanged to its end.
- R8: During write beats, `beat_mask_o` equals `dm_i` of the same cycle, bit 0 for the even beat and bit 1 for the odd beat. During reads and idle cycles it is 0.
- R9: Address bit 10 high on a read selects auto-precharge. `pre_start_o` pulses for one cycle, length/2 cycles after the command, with the bank on `pre_bank_o`. This holds when the bank's minimum active time has already been met.
- R10: A bank counts as active-ready T_RAS cycles after its activate command. A read auto-precharge that falls due earlier is held until that cycle.
- R11: A write with auto-precharge strobes `pre_start_o` T_WR cycles after the cycle of its last beat pair.
- R12: After the strobe, `bank_lock_o` is high for exactly T_RP cycles. A read or write with bit 10 low produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | 2 | Bank of the command |
| addr_i | input | 11 | Column in bits 9..0, auto-precharge in bit 10 |
| dm_i | input | 2 | Write data mask for this cycle's two beats |
| bl_code_i | input | 2 | Burst-length code |
| ilv_i | input | 1 | Interleaved order when 1 |
| beat_vld_o | output | 1 | Beat pair valid |
| beat_wr_o | output | 1 | Pair belongs to a write |
| beat_bank_o | output | 2 | Bank of the current burst |
| col_even_o | output | 10 | Column of the even beat |
| col_odd_o | output | 10 | Column of the odd beat |
| beat_mask_o | output | 2 | Per-beat write mask |
| bst_err_o | output | 1 | Stop command seen during a write |
| pre_start_o | output | 1 | Internal precharge strobe |
| pre_bank_o | output | 2 | Bank of the scheduled precharge |
| bank_lock_o | output | 1 | Precharge time running |

## Verification
The bench sweeps every start offset for all three burst lengths, in both orders, for reads and writes. A sequencer that wraps across the aligned block, or that mixes up the two orders, shows wrong columns at the wrap point. Interrupts are aimed mid-burst. A design that finishes the old burst, or that gives the new one only the remaining length, ends at the wrong cycle or shows stale columns. Stop is applied in read, in write and in idle: a design that stops a write, or that misses the error flag, is caught. The precharge cases count cycles from the command. Firing before the active time is met, counting write recovery from the command rather than from the last data, or running the lock one cycle too long or too short all land on the wrong cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_BST = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_READ  = 2'd1,
        B_WRITE = 2'd2
    } bstate_e;

    typedef enum logic [1:0] {
        AP_IDLE = 2'd0,
        AP_WAIT = 2'd1,
        AP_LOCK = 2'd2
    } apstate_e;

    // log2 of the burst length; code 0 falls back to two beats
    function automatic logic [1:0] len_log2(input logic [1:0] code);
        return (code == 2'd0) ? 2'd1 : code;
    endfunction

endpackage

// File: rtl/bseq_colgen.sv
module bseq_colgen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [2:0]       idx_i,
    input  logic [1:0]       lg_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [2:0] wrap_m;
    logic [2:0] off;

    always_comb begin
        wrap_m = 3'((4'd1 << lg_i) - 4'd1);
        off    = ilv_i ? (base_i[2:0] ^ idx_i) : (base_i[2:0] + idx_i);
        col_o  = {base_i[COL_W-1:3], (base_i[2:0] & ~wrap_m) | (off & wrap_m)};
    end
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int BA_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_i,
    input  logic [BA_W-1:0]  bank_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [1:0]       dm_i,
    input  logic [1:0]       lg_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] base_o,
    output logic [1:0]       pair_o,
    output logic [1:0]       lg_o,
    output logic             ilv_o,
    output logic [BA_W-1:0]  bank_o,
    output logic             vld_o,
    output logic             wr_o,
    output logic [1:0]       mask_o,
    output logic             bst_err_o
);
    bstate_e          state_q, state_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [1:0]       pair_q, pair_d;
    logic [1:0]       lg_q, lg_d;
    logic             ilv_q, ilv_d;
    logic [BA_W-1:0]  bank_q, bank_d;
    logic [1:0]       last_pair;
    logic             new_burst;

    always_comb begin
        unique case (lg_q)
            2'd1:    last_pair = 2'd0;
            2'd2:    last_pair = 2'd1;
            default: last_pair = 2'd3;
        endcase
    end

    assign new_burst = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);

    // next-state: start-read/start-write, advance, done, stop
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        pair_d  = pair_q;
        lg_d    = lg_q;
        ilv_d   = ilv_q;
        bank_d  = bank_q;
        if (new_burst) begin
            state_d = (cmd_i == CMD_RD) ? B_READ : B_WRITE;
            base_d  = col_i;
            pair_d  = 2'd0;
            lg_d    = lg_i;
            ilv_d   = ilv_i;
            bank_d  = bank_i;
        end else begin
            unique case (state_q)
                B_IDLE: state_d = B_IDLE;
                B_READ: begin
                    if (cmd_i == CMD_BST || pair_q == last_pair) state_d = B_IDLE;
                    else pair_d = pair_q + 2'd1;
                end
                B_WRITE: begin
                    if (pair_q == last_pair) state_d = B_IDLE;
                    else pair_d = pair_q + 2'd1;
                end
                default: state_d = B_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= B_IDLE;
            base_q  <= '0;
            pair_q  <= '0;
            lg_q    <= 2'd1;
            ilv_q   <= 1'b0;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            pair_q  <= pair_d;
            lg_q    <= lg_d;
            ilv_q   <= ilv_d;
            bank_q  <= bank_d;
        end
    end

    always_comb begin
        vld_o     = (state_q != B_IDLE);
        wr_o      = (state_q == B_WRITE);
        mask_o    = (state_q == B_WRITE) ? dm_i : 2'b00;
        bst_err_o = (state_q == B_WRITE) && (cmd_i == CMD_BST);
        base_o    = base_q;
        pair_o    = pair_q;
        lg_o      = lg_q;
        ilv_o     = ilv_q;
        bank_o    = bank_q;
    end
endmodule

// File: rtl/bseq_apsched.sv
module bseq_apsched
    import bseq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int T_RAS     = 6,
    parameter int T_WR      = 2,
    parameter int T_RP      = 3,
    parameter int CNT_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cmd_i,
    input  logic [BA_W-1:0] bank_i,
    input  logic            ap_i,
    input  logic [1:0]      lg_i,
    output logic            pre_start_o,
    output logic [BA_W-1:0] pre_bank_o,
    output logic            lock_o
);
    localparam int RAS_W = (T_RAS > 1) ? $clog2(T_RAS + 1) : 1;

    logic [NUM_BANKS-1:0] ras_ok;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ras
        logic [RAS_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else if (cmd_i == CMD_ACT && bank_i == BA_W'(b)) cnt_q <= RAS_W'(T_RAS - 1);
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
        assign ras_ok[b] = (cnt_q == '0);
    end

    apstate_e         state_q, state_d;
    logic [CNT_W-1:0] tmr_q, tmr_d;
    logic [BA_W-1:0]  abank_q, abank_d;
    logic [CNT_W-1:0] half;
    logic             arm;
    logic             fire;

    always_comb begin
        unique case (lg_i)
            2'd1:    half = CNT_W'(1);
            2'd2:    half = CNT_W'(2);
            default: half = CNT_W'(4);
        endcase
    end

    assign arm  = ap_i && ((cmd_i == CMD_RD) || (cmd_i == CMD_WR));
    assign fire = (state_q == AP_WAIT) && (tmr_q == '0) && ras_ok[abank_q];

    // next-state: arm, fire, release
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        abank_d = abank_q;
        if (arm) begin
            state_d = AP_WAIT;
            abank_d = bank_i;
            tmr_d   = (cmd_i == CMD_RD) ? (half - CNT_W'(1))
                                        : (half + CNT_W'(T_WR) - CNT_W'(1));
        end else begin
            unique case (state_q)
                AP_IDLE: state_d = AP_IDLE;
                AP_WAIT: begin
                    if (fire) begin
                        state_d = AP_LOCK;
                        tmr_d   = CNT_W'(T_RP - 1);
                    end else if (tmr_q != '0) begin
                        tmr_d = tmr_q - CNT_W'(1);
                    end
                end
                AP_LOCK: begin
                    if (tmr_q == '0) state_d = AP_IDLE;
                    else tmr_d = tmr_q - CNT_W'(1);
                end
                default: state_d = AP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AP_IDLE;
            tmr_q   <= '0;
            abank_q <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            abank_q <= abank_d;
        end
    end

    always_comb begin
        pre_start_o = fire;
        pre_bank_o  = abank_q;
        lock_o      = (state_q == AP_LOCK);
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import bseq_pkg::*;
#(
    parameter int COL_W     = 10,
    parameter int AP_BIT    = 10,
    parameter int ADDR_W    = 11,
    parameter int NUM_BANKS = 4,
    parameter int T_RAS     = 6,
    parameter int T_WR      = 2,
    parameter int T_RP      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [1:0]                   dm_i,
    input  logic [1:0]                   bl_code_i,
    input  logic                         ilv_i,
    output logic                         beat_vld_o,
    output logic                         beat_wr_o,
    output logic [$clog2(NUM_BANKS)-1:0] beat_bank_o,
    output logic [COL_W-1:0]             col_even_o,
    output logic [COL_W-1:0]             col_odd_o,
    output logic [1:0]                   beat_mask_o,
    output logic                         bst_err_o,
    output logic                         pre_start_o,
    output logic [$clog2(NUM_BANKS)-1:0] pre_bank_o,
    output logic                         bank_lock_o
);
    localparam int BA_W  = $clog2(NUM_BANKS);
    localparam int CNT_W = $clog2(4 + T_WR + T_RP + 1) + 1;

    logic [1:0]       lg_in;
    logic [COL_W-1:0] base;
    logic [1:0]       pair;
    logic [1:0]       lg_q;
    logic             ilv_q;
    logic [COL_W-1:0] lane_col [2];

    assign lg_in = len_log2(bl_code_i);

    bseq_ctrl #(.COL_W(COL_W), .BA_W(BA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd_i),
        .bank_i    (bank_i),
        .col_i     (addr_i[COL_W-1:0]),
        .dm_i      (dm_i),
        .lg_i      (lg_in),
        .ilv_i     (ilv_i),
        .base_o    (base),
        .pair_o    (pair),
        .lg_o      (lg_q),
        .ilv_o     (ilv_q),
        .bank_o    (beat_bank_o),
        .vld_o     (beat_vld_o),
        .wr_o      (beat_wr_o),
        .mask_o    (beat_mask_o),
        .bst_err_o (bst_err_o)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        bseq_colgen #(.COL_W(COL_W)) u_gen (
            .base_i (base),
            .idx_i  ({pair, 1'(g)}),
            .lg_i   (lg_q),
            .ilv_i  (ilv_q),
            .col_o  (lane_col[g])
        );
    end

    assign col_even_o = lane_col[0];
    assign col_odd_o  = lane_col[1];

    bseq_apsched #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W),
        .T_RAS     (T_RAS),
        .T_WR      (T_WR),
        .T_RP      (T_RP),
        .CNT_W     (CNT_W)
    ) u_ap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd_i),
        .bank_i      (bank_i),
        .ap_i        (addr_i[AP_BIT]),
        .lg_i        (lg_in),
        .pre_start_o (pre_start_o),
        .pre_bank_o  (pre_bank_o),
        .lock_o      (bank_lock_o)
    );
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int ADDR_W = 11,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              beat_vld_o,
    input logic              beat_wr_o,
    input logic [1:0]        beat_mask_o,
    input logic              bst_err_o,
    input logic              pre_start_o,
    input logic              bank_lock_o
);
    AST_MASK_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_mask_o != 2'b00) |-> (beat_vld_o && beat_wr_o)); // R8

    AST_STOP_ERR_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bst_err_o |-> (beat_vld_o && beat_wr_o && cmd_i == 3'd4)); // R7

    AST_READ_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !beat_wr_o && cmd_i == 3'd4) |=> !beat_vld_o); // R6

    AST_STROBE_THEN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_start_o && !(addr_i[AP_BIT] && (cmd_i == 3'd2 || cmd_i == 3'd3)))
        |=> (bank_lock_o && !pre_start_o)); // R12

    AST_NO_STROBE_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        bank_lock_o |-> !pre_start_o); // R12
endmodule

bind burst_seq bseq_chk #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .addr_i      (addr_i),
    .beat_vld_o  (beat_vld_o),
    .beat_wr_o   (beat_wr_o),
    .beat_mask_o (beat_mask_o),
    .bst_err_o   (bst_err_o),
    .pre_start_o (pre_start_o),
    .bank_lock_o (bank_lock_o)
);

// File: tb/tb_burst_seq.sv
module tb_burst_seq;
    localparam int CLK_PERIOD = 10;
    localparam int T_RAS = 6;
    localparam int T_WR  = 2;
    localparam int T_RP  = 3;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, BST = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = NOP;
    logic [1:0]  bank = 2'd0;
    logic [10:0] addr = '0;
    logic [1:0]  dm = 2'b00;
    logic [1:0]  blc = 2'd1;
    logic        ilv = 1'b0;
    logic        vld, wr, berr, pre, lock;
    logic [1:0]  bbank, mask, pbank;
    logic [9:0]  ce, co;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .addr_i(addr),
        .dm_i(dm), .bl_code_i(blc), .ilv_i(ilv),
        .beat_vld_o(vld), .beat_wr_o(wr), .beat_bank_o(bbank),
        .col_even_o(ce), .col_odd_o(co), .beat_mask_o(mask), .bst_err_o(berr),
        .pre_start_o(pre), .pre_bank_o(pbank), .bank_lock_o(lock)
    );

    task automatic expect_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle's inputs, then settle; outputs observed belong to this cycle
    task automatic cyc(input logic [2:0] c, input logic [1:0] b, input logic [10:0] a,
                       input logic [1:0] d);
        @(negedge clk);
        cmd = c; bank = b; addr = a; dm = d;
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(NOP, 2'd0, 11'd0, 2'b00);
    endtask

    function automatic int expcol(input int start, input int i, input int bl, input int il);
        int lo;
        lo = il ? ((start % bl) ^ i) : (((start % bl) + i) % bl);
        return (start / bl) * bl + lo;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_eq("reset vld R1", vld, 0);
        expect_eq("reset pre R9", pre, 0);
        expect_eq("reset lock R12", lock, 0);
        expect_eq("reset err R7", berr, 0);

        // sweep: R1 sequential, R2 interleaved, R3 lengths and read/write flag
        for (int code = 1; code <= 3; code++) begin
            for (int il = 0; il < 2; il++) begin
                for (int rw = 0; rw < 2; rw++) begin
                    int bl;
                    bl = 1 << code;
                    for (int s = 0; s < bl; s++) begin
                        int st;
                        st = 944 + s;
                        blc = 2'(code); ilv = il[0];
                        cyc(rw ? WR : RD, 2'(s), 11'(st), 2'b00);
                        for (int p = 0; p < bl / 2; p++) begin
                            cyc(NOP, 2'd0, 11'd0, 2'b00);
                            expect_eq(il ? "even col R2" : "even col R1", ce, expcol(st, 2 * p, bl, il));
                            expect_eq(il ? "odd col R2" : "odd col R1", co, expcol(st, 2 * p + 1, bl, il));
                            expect_eq("valid in burst R3", vld, 1);
                            expect_eq("write flag R3", wr, rw);
                            expect_eq("burst bank R1", bbank, s % 4);
                        end
                        cyc(NOP, 2'd0, 11'd0, 2'b00);
                        expect_eq("valid after burst R3", vld, 0);
                    end
                end
            end
        end
        blc = 2'd0; ilv = 1'b0;
        cyc(RD, 2'd0, 11'd20, 2'b00);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("code0 even R3", ce, 20);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("code0 length R3", vld, 0);

        // R4: read interrupted by read to another bank
        blc = 2'd3; ilv = 1'b0;
        cyc(RD, 2'd0, 11'd16, 2'b00);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("pre-interrupt pair0 R4", ce, 16);
        cyc(RD, 2'd2, 11'd35, 2'b00);
        expect_eq("old pair1 still out R4", ce, 18);
        for (int p = 0; p < 4; p++) begin
            cyc(NOP, 2'd0, 11'd0, 2'b00);
            expect_eq("new burst even R4", ce, expcol(35, 2 * p, 8, 0));
            expect_eq("new burst odd R4", co, expcol(35, 2 * p + 1, 8, 0));
            expect_eq("new burst bank R4", bbank, 2);
        end
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("interrupted burst full length R4", vld, 0);

        // R5: write interrupted by adjacent write
        blc = 2'd2;
        cyc(WR, 2'd1, 11'd8, 2'b00);
        cyc(WR, 2'd1, 11'd21, 2'b00);
        expect_eq("first write pair0 R5", ce, 8);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("second write pair0 even R5", ce, 21);
        expect_eq("second write pair0 odd R5", co, 22);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("second write pair1 even R5", ce, 23);
        expect_eq("second write pair1 odd R5", co, 20);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("second write ends R5", vld, 0);

        // R6: stop during read, stop while idle
        blc = 2'd3;
        cyc(RD, 2'd0, 11'd0, 2'b00);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        cyc(BST, 2'd0, 11'd0, 2'b00);
        expect_eq("pair in stop cycle R6", ce, 2);
        expect_eq("no error on read stop R6", berr, 0);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("read stopped R6", vld, 0);
        cyc(BST, 2'd0, 11'd0, 2'b00);
        expect_eq("idle stop no error R6", berr, 0);
        expect_eq("idle stop no valid R6", vld, 0);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("idle stop after R6", vld, 0);

        // R7: stop during write is flagged, write continues
        blc = 2'd2;
        cyc(WR, 2'd0, 11'd4, 2'b00);
        cyc(BST, 2'd0, 11'd0, 2'b00);
        expect_eq("write stop flagged R7", berr, 1);
        expect_eq("write pair0 R7", ce, 4);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("write continues R7", vld, 1);
        expect_eq("write pair1 R7", ce, 6);
        expect_eq("flag one cycle R7", berr, 0);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("write end R7", vld, 0);

        // R8: mask pass-through on writes, zero on reads
        cyc(WR, 2'd0, 11'd0, 2'b11);
        expect_eq("idle mask zero R8", mask, 0);
        cyc(NOP, 2'd0, 11'd0, 2'b10);
        expect_eq("write mask pair0 R8", mask, 2);
        cyc(NOP, 2'd0, 11'd0, 2'b01);
        expect_eq("write mask pair1 R8", mask, 1);
        cyc(RD, 2'd0, 11'd0, 2'b11);
        cyc(NOP, 2'd0, 11'd0, 2'b11);
        expect_eq("read mask zero R8", mask, 0);
        idle(2);

        // R9 + R12: read auto-precharge with active time met
        cyc(ACT, 2'd1, 11'd0, 2'b00);
        idle(8);
        blc = 2'd2;
        cyc(RD, 2'd1, 11'h405, 2'b00);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("no strobe yet R9", pre, 0);
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("read strobe at BL/2 R9", pre, 1);
        expect_eq("strobe bank R9", pbank, 1);
        for (int k = 0; k < T_RP; k++) begin
            cyc(NOP, 2'd0, 11'd0, 2'b00);
            expect_eq("lock held R12", lock, 1);
            expect_eq("single strobe R12", pre, 0);
        end
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("lock released R12", lock, 0);

        // R10: active time not yet met
        cyc(ACT, 2'd3, 11'd0, 2'b00);
        cyc(RD, 2'd3, 11'h400, 2'b00);
        for (int k = 1; k < T_RAS - 1; k++) begin
            cyc(NOP, 2'd0, 11'd0, 2'b00);
            expect_eq("deferred strobe R10", pre, 0);
        end
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("strobe at active time R10", pre, 1);
        expect_eq("deferred bank R10", pbank, 3);
        idle(T_RP + 2);

        // R11: write auto-precharge after recovery
        blc = 2'd3;
        cyc(WR, 2'd1, 11'h400, 2'b00);
        for (int k = 1; k < 4 + T_WR; k++) begin
            cyc(NOP, 2'd0, 11'd0, 2'b00);
            expect_eq("write recovery wait R11", pre, 0);
        end
        cyc(NOP, 2'd0, 11'd0, 2'b00);
        expect_eq("write strobe R11", pre, 1);
        idle(T_RP + 2);

        // R12: no auto-precharge when bit 10 low
        blc = 2'd2;
        cyc(RD, 2'd1, 11'd5, 2'b00);
        for (int k = 0; k < 8; k++) begin
            cyc(NOP, 2'd0, 11'd0, 2'b00);
            expect_eq("no strobe without bit10 R12", pre, 0);
            expect_eq("no lock without bit10 R12", lock, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule